// File: doc/BRIEF.md
# Double-Buffered Converter Code Front End

This block is the digital side of a 10-bit converter, modelled synchronously. A host writes a code into an input latch, and the code is later copied into a second holding register whose contents drive the converter. On an 8-bit bus the code is left-justified and takes two writes. The first write carries the eight upper bits on bus lines 9..2. The second write carries the two lowest bits on bus lines 9..8. On a 10-bit bus one write loads the whole code.

A buffering-mode input selects one of three modes. In flow-through mode both registers follow the data bus. In single-buffered mode the output register always follows the latch. In double-buffered mode the output register changes only on a transfer, so many converters can be loaded ahead of time and then updated together by one shared transfer strobe. The transfer condition includes the low-byte select. Because of this, holding transfer active makes the second byte write update the output in the same operation. An optional signed path turns two's complement input into offset binary by inverting the top code bit as it is loaded.

All controls are active low and are sampled on the rising clock edge. Each register takes its new value on the edge where the controls are seen.

Top module: `dac_front_end`

## Requirements
- R1: While `rst` is high at a rising edge, both `latch_q` and `code_q` become 0 after that edge.
- R2: Outside flow-through mode, a write happens only when both `cs_n` and `wr_n` are low at the edge. Otherwise `latch_q` keeps its value.
- R3: A write with `byte_sel` = 1 loads `din[9:0]` into all ten latch bits, with `din[0]` as the least significant bit.
- R4: A write with `byte_sel` = 0 loads `din[9:8]` into latch bits 1..0 and leaves latch bits 9..2 unchanged.
- R5: In double-buffered mode, `code_q` takes the latch value when `xfer_n`, `wr_n` and `byte_sel` are all low at an edge. `cs_n` is not part of this condition. If a low-byte write happens at the same edge, the transferred value already includes the new low bits.
- R6: In double-buffered mode, `code_q` holds when `byte_sel` is high or `xfer_n` is high, even while the latch is being written.
- R7: In single-buffered mode, after every edge `code_q` equals the new latch contents.
- R8: In flow-through mode, both registers load the full `din` on every edge whatever the control levels are.
- R9: With `signed_en` = 1, bit 9 is inverted whenever the upper latch section loads: input 0x200 (-512) stores 0x000, 0x000 stores 0x200, and 0x1FF (+511) stores 0x3FF.
- R10: `mode` encoding: 2'b00 selects flow-through, 2'b01 single-buffered, 2'b10 double-buffered, and 2'b11 behaves as double-buffered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low, enables writes |
| wr_n | input | 1 | Write strobe, active low |
| xfer_n | input | 1 | Transfer strobe, active low |
| byte_sel | input | 1 | 1: write fills all ten bits; 0: write fills low two bits and permits transfer |
| din | input | 10 | Data bus, bit 0 least significant |
| mode | input | 2 | Buffering mode select |
| signed_en | input | 1 | Invert bit 9 on load (two's complement to offset binary) |
| latch_q | output | 10 | Input latch contents |
| code_q | output | 10 | Output register contents driving the converter |

## Verification
The loading of the low byte and the transfer to the output register can fall on the same edge. When they do, the output must show the freshly completed code and not the old latch value. The bench provokes this by holding `xfer_n` low during the second byte write. It also issues a transfer-only strobe with `cs_n` high, and a full-word write with `xfer_n` low, where the latch must change while the output holds. Each edge is judged against a reference model that updates both registers from the same sampled controls.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

    localparam int CODE_W = 10;
    localparam int HI_W   = 8;
    localparam int LO_W   = CODE_W - HI_W;
    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_FLOW       = 2'b00,
        MODE_SINGLE     = 2'b01,
        MODE_DOUBLE     = 2'b10,
        MODE_DOUBLE_ALT = 2'b11
    } buf_mode_e;

    typedef struct packed {
        logic [HI_W-1:0] hi;
        logic [LO_W-1:0] lo;
    } code_word_t;

    typedef struct packed {
        logic load_hi;
        logic load_lo;
        logic lo_from_top;
        logic load_dac;
    } fe_ctrl_t;

    // Two's complement to offset binary: flip the top code bit.
    function automatic logic [HI_W-1:0] map_upper(input logic [HI_W-1:0] h,
                                                  input logic sgn);
        return {h[HI_W-1] ^ sgn, h[HI_W-2:0]};
    endfunction

endpackage

// File: rtl/dacfe_ctrl.sv
module dacfe_ctrl
    import dacfe_pkg::*;
(
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              xfer_n,
    input  logic              byte_sel,
    input  logic [MODE_W-1:0] mode,
    output fe_ctrl_t          ctrl
);

    buf_mode_e mode_e;
    logic      flow;
    logic      single;
    logic      write_ok;
    logic      xfer_ok;

    always_comb begin
        mode_e   = buf_mode_e'(mode);
        flow     = (mode_e == MODE_FLOW);
        single   = (mode_e == MODE_SINGLE);
        write_ok = !cs_n && !wr_n;
        // Transfer gate does not involve chip select, so one strobe can serve many parts.
        xfer_ok  = !xfer_n && !wr_n && !byte_sel;

        ctrl.load_hi     = flow || (write_ok && byte_sel);
        ctrl.load_lo     = flow || write_ok;
        ctrl.lo_from_top = !flow && !byte_sel;
        ctrl.load_dac    = flow || single || xfer_ok;
    end

endmodule

// File: rtl/dacfe_input_latch.sv
module dacfe_input_latch
    import dacfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  fe_ctrl_t          ctrl,
    input  logic [CODE_W-1:0] din,
    input  logic              signed_en,
    output code_word_t        cur_q,
    output code_word_t        nxt
);

    code_word_t held;

    always_comb begin
        nxt = held;
        if (ctrl.load_hi)
            nxt.hi = map_upper(din[CODE_W-1 -: HI_W], signed_en);
        if (ctrl.load_lo)
            nxt.lo = ctrl.lo_from_top ? din[CODE_W-1 -: LO_W] : din[LO_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            held <= '0;
        else
            held <= nxt;
    end

    assign cur_q = held;

endmodule

// File: rtl/dacfe_dac_reg.sv
module dacfe_dac_reg
    import dacfe_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  code_word_t d,
    output code_word_t q
);

    code_word_t r;

    always_ff @(posedge clk) begin
        if (rst)
            r <= '0;
        else if (load)
            r <= d;
    end

    assign q = r;

endmodule

// File: rtl/dac_front_end.sv
module dac_front_end
    import dacfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              xfer_n,
    input  logic              byte_sel,
    input  logic [CODE_W-1:0] din,
    input  logic [MODE_W-1:0] mode,
    input  logic              signed_en,
    output logic [CODE_W-1:0] latch_q,
    output logic [CODE_W-1:0] code_q
);

    fe_ctrl_t   ctrl;
    code_word_t latch_cur;
    code_word_t latch_nxt;
    code_word_t dac_cur;

    dacfe_ctrl u_ctrl (
        .cs_n     (cs_n),
        .wr_n     (wr_n),
        .xfer_n   (xfer_n),
        .byte_sel (byte_sel),
        .mode     (mode),
        .ctrl     (ctrl)
    );

    dacfe_input_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .din       (din),
        .signed_en (signed_en),
        .cur_q     (latch_cur),
        .nxt       (latch_nxt)
    );

    // The output register takes the latch's next value so a write and a transfer can share an edge.
    dacfe_dac_reg u_dac (
        .clk  (clk),
        .rst  (rst),
        .load (ctrl.load_dac),
        .d    (latch_nxt),
        .q    (dac_cur)
    );

    assign latch_q = latch_cur;
    assign code_q  = dac_cur;

endmodule

// File: rtl/dacfe_checker.sv
module dacfe_checker
    import dacfe_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              wr_n,
    input logic              xfer_n,
    input logic              byte_sel,
    input logic [CODE_W-1:0] din,
    input logic [MODE_W-1:0] mode,
    input logic              signed_en,
    input logic [CODE_W-1:0] latch_q,
    input logic [CODE_W-1:0] code_q
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (latch_q == '0 && code_q == '0));

    assert_no_write_unselected_R2: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_FLOW && (cs_n || wr_n)) |=> $stable(latch_q));

    assert_upper_kept_R4: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_FLOW && !byte_sel) |=> $stable(latch_q[CODE_W-1:LO_W]));

    assert_full_word_load_R3: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_FLOW && !cs_n && !wr_n && byte_sel && !signed_en)
        |=> (latch_q == $past(din)));

    assert_no_xfer_hi_sel_R6: assert property (@(posedge clk) disable iff (rst)
        (mode[1] && (byte_sel || xfer_n)) |=> $stable(code_q));

    assert_xfer_copies_R5: assert property (@(posedge clk) disable iff (rst)
        (mode[1] && !xfer_n && !wr_n && !byte_sel) |=> (code_q == latch_q));

    assert_single_follows_R7: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SINGLE) |=> (code_q == latch_q));

    assert_flow_through_R8: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_FLOW && !signed_en) |=> (latch_q == $past(din) && code_q == $past(din)));

endmodule

bind dac_front_end dacfe_checker u_dacfe_checker (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .wr_n      (wr_n),
    .xfer_n    (xfer_n),
    .byte_sel  (byte_sel),
    .din       (din),
    .mode      (mode),
    .signed_en (signed_en),
    .latch_q   (latch_q),
    .code_q    (code_q)
);

// File: tb/dac_front_end_bench.sv
module dac_front_end_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 200000;

    typedef struct {
        logic [9:0] exp_latch;
        logic [9:0] exp_code;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       wr_n = 1'b1;
    logic       xfer_n = 1'b1;
    logic       byte_sel = 1'b1;
    logic [9:0] din = '0;
    logic [1:0] mode = 2'b10;
    logic       signed_en = 1'b0;
    logic [9:0] latch_q;
    logic [9:0] code_q;

    int   checks = 0;
    int   errors = 0;
    bit   finished = 1'b0;
    exp_t sb[$];

    logic [9:0] m_latch = '0;
    logic [9:0] m_code = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_front_end u_dac_front_end (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .wr_n      (wr_n),
        .xfer_n    (xfer_n),
        .byte_sel  (byte_sel),
        .din       (din),
        .mode      (mode),
        .signed_en (signed_en),
        .latch_q   (latch_q),
        .code_q    (code_q)
    );

    // Driver: apply one edge worth of controls and push the expected result.
    task automatic step(input logic r, input logic c, input logic w, input logic x,
                        input logic b, input logic [9:0] d, input logic [1:0] md,
                        input logic sg, input string tag);
        logic [9:0] nl;
        exp_t e;
        @(negedge clk);
        rst = r; cs_n = c; wr_n = w; xfer_n = x; byte_sel = b;
        din = d; mode = md; signed_en = sg;
        if (r) begin
            m_latch = '0;
            m_code  = '0;
        end else begin
            nl = m_latch;
            if (md == 2'b00)
                nl = {d[9] ^ sg, d[8:0]};
            else if (!c && !w) begin
                if (b) nl = {d[9] ^ sg, d[8:0]};
                else   nl[1:0] = d[9:8];
            end
            if (md == 2'b00 || md == 2'b01 || (!x && !w && !b))
                m_code = nl;
            m_latch = nl;
        end
        e.exp_latch = m_latch;
        e.exp_code  = m_code;
        e.tag       = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare once the edge has settled.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (latch_q !== e.exp_latch) begin
                    errors++;
                    $display("FAIL %s latch_q actual %h expected %h", e.tag, latch_q, e.exp_latch);
                end
                checks++;
                if (code_q !== e.exp_code) begin
                    errors++;
                    $display("FAIL %s code_q actual %h expected %h", e.tag, code_q, e.exp_code);
                end
            end
        end
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset with busy inputs
        step(1, 0, 0, 0, 1, 10'h3FF, 2'b10, 0, "R1");
        step(1, 0, 0, 0, 0, 10'h155, 2'b10, 0, "R1");

        // R3 / R6: full word write in double mode, no transfer
        step(0, 0, 0, 1, 1, 10'h2B4, 2'b10, 0, "R3");
        // R4 / R6: low byte write on top lines, upper kept, output holds
        step(0, 0, 0, 1, 0, 10'h0C0, 2'b10, 0, "R4");
        // R2: not selected, or no write strobe
        step(0, 1, 0, 1, 1, 10'h111, 2'b10, 0, "R2");
        step(0, 0, 1, 1, 1, 10'h222, 2'b10, 0, "R2");
        step(0, 1, 1, 0, 0, 10'h333, 2'b10, 0, "R2");
        // R5: third-write transfer with chip select inactive
        step(0, 1, 0, 0, 0, 10'h000, 2'b10, 0, "R5");
        // R5: automatic transfer on second byte
        step(0, 0, 0, 0, 1, 10'h155, 2'b10, 0, "R6");
        step(0, 0, 0, 0, 0, 10'h200, 2'b10, 0, "R5");
        step(0, 0, 0, 0, 0, 10'h100, 2'b10, 0, "R5");
        // R6: new data loaded while output holds
        step(0, 0, 0, 0, 1, 10'h0F3, 2'b10, 0, "R6");
        step(0, 0, 0, 1, 0, 10'h300, 2'b10, 0, "R6");
        step(0, 1, 1, 1, 1, 10'h3FF, 2'b10, 0, "R6");
        // R10: code 11 behaves as double-buffered
        step(0, 0, 0, 1, 1, 10'h0AA, 2'b11, 0, "R10");
        step(0, 1, 0, 0, 0, 10'h000, 2'b11, 0, "R10");

        // R7: single-buffered, output follows each write
        step(0, 0, 0, 1, 1, 10'h3C3, 2'b01, 0, "R7");
        step(0, 0, 0, 1, 0, 10'h100, 2'b01, 0, "R7");
        step(0, 1, 1, 1, 1, 10'h055, 2'b01, 0, "R7");

        // R8: flow-through ignores controls
        step(0, 1, 1, 1, 1, 10'h123, 2'b00, 0, "R8");
        step(0, 1, 1, 1, 0, 10'h3FE, 2'b00, 0, "R8");
        step(0, 0, 0, 0, 0, 10'h001, 2'b00, 0, "R8");

        // R9: signed path, -512, 0, +511 and a low-byte write that leaves bit 9 alone
        step(0, 0, 0, 1, 1, 10'h200, 2'b01, 1, "R9");
        step(0, 0, 0, 1, 1, 10'h000, 2'b01, 1, "R9");
        step(0, 0, 0, 1, 1, 10'h1FF, 2'b01, 1, "R9");
        step(0, 0, 0, 1, 0, 10'h000, 2'b01, 1, "R9");

        // R1: reset again from a non-zero state
        step(1, 1, 1, 1, 1, 10'h000, 2'b10, 0, "R1");
        step(0, 1, 1, 1, 1, 10'h000, 2'b10, 0, "R1");

        repeat (3) @(posedge clk);
        #2;
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule